// File: doc/BRIEF.md
# VGA host odd/even plane mapper

This block sits between the host side of a VGA-style video memory window and four byte-wide memory planes. For each CPU access it decides which planes a write reaches, which plane a read returns its byte from, and the word address that all four planes share. Two addressing schemes are supported. In planar (sequential) addressing the host offset is the plane address, and the map mask chooses the written planes. In odd/even addressing, host bit A0 picks the even planes (0, 2) or the odd planes (1, 3), and a page bit takes the place of A0 in the plane address.

Writes and reads take their odd/even enable from different configuration bits. One direction can therefore run odd/even while the other runs planar. A small register port loads the configuration. It shares the host data byte as its write data. The plane outputs are purely combinational from the strobes, the offset and the stored configuration. Raster operations, data latches, bit masking, chain-4 and display fetch live elsewhere.

Top module: `hom_mapper`

## Requirements
- R1: After reset every configuration field is zero. A host write then enables no plane. A host read selects plane 0 and uses the host offset unchanged as the plane address.
- R2: Host writes use odd/even addressing exactly when bit 2 of the memory-mode register (select 0) is 0. No other bit of that register changes write behaviour.
- R3: In odd/even write addressing, plane p is enabled only if bit p of the map mask (select 1, bits 3:0) is set and bit 0 of p equals host A0. An even offset never enables plane 1 or 3, and an odd offset never enables plane 0 or 2.
- R4: In planar write addressing, `plane_we` equals the map mask and `plane_addr` equals `host_off`.
- R5: Host reads use odd/even addressing exactly when bit 4 of the graphics-mode register (select 3) is 1. The read plane is then {read-map bit 1, A0}, where the read map is select 2, bits 1:0.
- R6: In planar read addressing, `rd_plane` equals the 2-bit read-map value and `plane_addr` equals `host_off`.
- R7: The write and read odd/even enables are independent. A write can be planar while a read is odd/even, and the reverse.
- R8: In odd/even addressing (either direction), `plane_addr` is `host_off` with bit 0 replaced by the page bit (select 5, bit 0). A page value of 0 selects the low page and 1 selects the high page.
- R9: A write to the miscellaneous register (select 4) has no effect on any output.
- R10: A register write takes effect at the next clock edge. A host access in the same cycle still sees the old configuration, and it carries the shared data byte on `plane_wdata`.
- R11: Without `host_wr`, no plane is write-enabled. `plane_rd` is `host_rd` gated off by `host_wr`. `plane_wdata` always equals `host_wdata`. `plane_addr` follows the write rule while `host_wr` is high and the read rule otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Configuration register write strobe |
| reg_sel | input | 3 | Register select: 0 mem mode, 1 map mask, 2 read map, 3 gfx mode, 4 misc, 5 page |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_off | input | 16 | Host offset within the memory window |
| host_wdata | input | 8 | Host write data, also the register write data |
| plane_we | output | 4 | Per-plane write enables |
| plane_rd | output | 1 | Plane read strobe |
| plane_addr | output | 16 | Shared plane word address |
| plane_wdata | output | 8 | Data presented to the planes |
| rd_plane | output | 2 | Plane whose byte is returned to the host |

## Verification
Corrupted configuration state shows up in the same cycle as the next host access. A stale or wrong map mask or mode bit shows as a wrong `plane_we` pattern. A wrong page or read-mode bit shows as a flipped `plane_addr[0]` or a wrong `rd_plane`. Every register write is therefore followed by accesses at both parities of A0, so that a fault is seen within a cycle or two of the write that caused it. Register timing is checked by accessing in the write cycle itself and in the cycle that follows.

// File: rtl/hom_pkg.sv
package hom_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int PLANES  = 4;
    localparam int PIDX_W  = $clog2(PLANES);
    localparam int SEL_W   = 3;

    localparam int MM_PLANAR_BIT = 2;
    localparam int GM_OE_RD_BIT  = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_MEMMODE = 3'd0,
        SEL_MASK    = 3'd1,
        SEL_RDMAP   = 3'd2,
        SEL_GFXMODE = 3'd3,
        SEL_MISC    = 3'd4,
        SEL_PAGE    = 3'd5
    } hom_sel_e;

    typedef struct packed {
        logic              planar_wr;
        logic [PLANES-1:0] map_mask;
        logic [PIDX_W-1:0] rd_map;
        logic              oe_rd;
        logic              page;
    } hom_cfg_t;

    function automatic logic [ADDR_W-1:0] oe_addr(input logic [ADDR_W-1:0] off,
                                                  input logic page);
        return {off[ADDR_W-1:1], page};
    endfunction
endpackage

// File: rtl/hom_cfg_regs.sv
module hom_cfg_regs
    import hom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output hom_cfg_t          cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_we) begin
            case (hom_sel_e'(reg_sel))
                SEL_MEMMODE: cfg.planar_wr <= wdata[MM_PLANAR_BIT];
                SEL_MASK:    cfg.map_mask  <= wdata[PLANES-1:0];
                SEL_RDMAP:   cfg.rd_map    <= wdata[PIDX_W-1:0];
                SEL_GFXMODE: cfg.oe_rd     <= wdata[GM_OE_RD_BIT];
                SEL_PAGE:    cfg.page      <= wdata[0];
                default:     ;
            endcase
        end
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) $past(rst) |-> cfg == '0)
        else $error("config not cleared by reset");

    // R10
    a_r10_mask_next: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == SEL_MASK) |=> cfg.map_mask == $past(wdata[PLANES-1:0]))
        else $error("map mask not loaded on next edge");

    // R9
    a_r9_misc_inert: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == SEL_MISC) |=> $stable(cfg))
        else $error("misc write altered config");
endmodule

// File: rtl/hom_wmap.sv
module hom_wmap
    import hom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  hom_cfg_t          cfg,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_off,
    output logic [PLANES-1:0] we,
    output logic [ADDR_W-1:0] waddr
);
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        localparam logic PAR = p[0];
        logic par_ok;
        assign par_ok = cfg.planar_wr || (host_off[0] == PAR);
        assign we[p]  = host_wr && cfg.map_mask[p] && par_ok;
    end

    assign waddr = cfg.planar_wr ? host_off : oe_addr(host_off, cfg.page);

    logic [PLANES-1:0] wrong_par;
    always_comb begin
        for (int p = 0; p < PLANES; p++) wrong_par[p] = (p % 2 == 1) != host_off[0];
    end

    // R3
    a_r3_parity: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !cfg.planar_wr) |-> (we & wrong_par) == '0)
        else $error("odd/even write reached wrong-parity plane");
endmodule

// File: rtl/hom_rmap.sv
module hom_rmap
    import hom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  hom_cfg_t          cfg,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_off,
    output logic [PIDX_W-1:0] rd_plane,
    output logic [ADDR_W-1:0] raddr
);
    always_comb begin
        if (cfg.oe_rd) begin
            rd_plane = {cfg.rd_map[PIDX_W-1:1], host_off[0]};
            raddr    = oe_addr(host_off, cfg.page);
        end else begin
            rd_plane = cfg.rd_map;
            raddr    = host_off;
        end
    end

    // R5
    a_r5_rd_parity: assert property (@(posedge clk) disable iff (rst)
        (host_rd && cfg.oe_rd) |-> rd_plane[0] == host_off[0])
        else $error("odd/even read plane parity wrong");

    // R6
    a_r6_rd_planar: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !cfg.oe_rd) |-> raddr == host_off)
        else $error("planar read address altered");
endmodule

// File: rtl/hom_mapper.sv
module hom_mapper
    import hom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [15:0]       host_off,
    input  logic [7:0]        host_wdata,
    output logic [3:0]        plane_we,
    output logic              plane_rd,
    output logic [15:0]       plane_addr,
    output logic [7:0]        plane_wdata,
    output logic [1:0]        rd_plane
);
    hom_cfg_t          cfg;
    logic [ADDR_W-1:0] waddr, raddr;

    hom_cfg_regs u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .wdata(host_wdata), .cfg(cfg)
    );

    hom_wmap u_wmap (
        .clk(clk), .rst(rst), .cfg(cfg), .host_wr(host_wr),
        .host_off(host_off), .we(plane_we), .waddr(waddr)
    );

    hom_rmap u_rmap (
        .clk(clk), .rst(rst), .cfg(cfg), .host_rd(host_rd),
        .host_off(host_off), .rd_plane(rd_plane), .raddr(raddr)
    );

    assign plane_addr  = host_wr ? waddr : raddr;
    assign plane_rd    = host_rd && !host_wr;
    assign plane_wdata = host_wdata;

    // R11
    a_r11_idle_no_we: assert property (@(posedge clk) disable iff (rst)
        !host_wr |-> plane_we == '0)
        else $error("plane enabled without host write");

    // R8
    a_r8_page_sub: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !cfg.planar_wr) |-> plane_addr[0] == cfg.page)
        else $error("page bit not substituted");

    // R4
    a_r4_planar_wr: assert property (@(posedge clk) disable iff (rst)
        (host_wr && cfg.planar_wr) |-> (plane_we == cfg.map_mask && plane_addr == host_off))
        else $error("planar write mapping wrong");
endmodule

// File: tb/hom_mapper_tb.sv
module hom_mapper_tb;
    logic clk = 0, rst = 1;
    logic reg_we = 0, host_wr = 0, host_rd = 0;
    logic [2:0] reg_sel = 0;
    logic [15:0] host_off = 0;
    logic [7:0] host_wdata = 0;
    logic [3:0] plane_we;
    logic plane_rd;
    logic [15:0] plane_addr;
    logic [7:0] plane_wdata;
    logic [1:0] rd_plane;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hom_mapper u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .host_wr(host_wr), .host_rd(host_rd), .host_off(host_off),
        .host_wdata(host_wdata), .plane_we(plane_we), .plane_rd(plane_rd),
        .plane_addr(plane_addr), .plane_wdata(plane_wdata), .rd_plane(rd_plane)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_reg(logic [2:0] sel, logic [7:0] val);
        @(negedge clk);
        reg_we = 1; reg_sel = sel; host_wdata = val;
        @(negedge clk);
        reg_we = 0;
    endtask

    // expected enables for an odd/even write
    function automatic logic [3:0] oe_we(logic [3:0] mask, logic a0);
        return mask & (a0 ? 4'b1010 : 4'b0101);
    endfunction

    task automatic wr(logic [15:0] off, logic [7:0] d);
        @(negedge clk);
        host_wr = 1; host_rd = 0; host_off = off; host_wdata = d;
        #1;
    endtask

    task automatic rd(logic [15:0] off);
        @(negedge clk);
        host_wr = 0; host_rd = 1; host_off = off;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        host_wr = 0; host_rd = 0;
    endtask

    task automatic t_reset();
        wr(16'h1234, 8'h5A);
        check("R1 we after reset", plane_we, 4'h0);
        rd(16'h1235);
        check("R1 rd_plane after reset", rd_plane, 2'd0);
        check("R1 read addr after reset", plane_addr, 16'h1235);
        idle();
    endtask

    task automatic t_oe_write();
        set_reg(0, 8'h00); set_reg(1, 8'h0F); set_reg(5, 8'h00);
        wr(16'h0100, 8'h11);
        check("R2 even we", plane_we, oe_we(4'hF, 0));
        check("R8 even addr low page", plane_addr, 16'h0100);
        wr(16'h0101, 8'h22);
        check("R3 odd we", plane_we, oe_we(4'hF, 1));
        check("R8 odd addr low page", plane_addr, 16'h0100);
        idle();
        set_reg(1, 8'h06);
        wr(16'h0300, 8'h33);
        check("R3 mask6 even", plane_we, 4'b0100);
        wr(16'h0301, 8'h33);
        check("R3 mask6 odd", plane_we, 4'b0010);
        idle();
        set_reg(0, 8'hFB);
        wr(16'h0301, 8'h44);
        check("R2 other memmode bits inert", plane_we, 4'b0010);
        idle();
        set_reg(0, 8'h00);
    endtask

    task automatic t_page();
        set_reg(1, 8'h0F); set_reg(5, 8'h01);
        wr(16'h0100, 8'h55);
        check("R8 high page even", plane_addr, 16'h0101);
        wr(16'h0101, 8'h55);
        check("R8 high page odd", plane_addr, 16'h0101);
        idle();
    endtask

    task automatic t_seq_write();
        set_reg(0, 8'h04); set_reg(1, 8'h0B); set_reg(2, 8'h03);
        wr(16'h0101, 8'h66);
        check("R4 planar we", plane_we, 4'hB);
        check("R4 planar addr", plane_addr, 16'h0101);
        rd(16'hBEEF);
        check("R6 planar rd plane", rd_plane, 2'd3);
        check("R6 planar rd addr", plane_addr, 16'hBEEF);
        idle();
    endtask

    task automatic t_oe_read();
        set_reg(3, 8'h10); set_reg(2, 8'h02); set_reg(5, 8'h00);
        rd(16'h0201);
        check("R5 oe rd plane odd", rd_plane, 2'd3);
        check("R8 oe rd addr", plane_addr, 16'h0200);
        set_reg(2, 8'h01);
        rd(16'h0200);
        check("R5 oe rd plane even", rd_plane, 2'd0);
        set_reg(5, 8'h01);
        rd(16'h0200);
        check("R8 oe rd addr high page", plane_addr, 16'h0201);
        idle();
    endtask

    task automatic t_indep();
        // write planar (memmode bit2=1), read odd/even (gfx bit4=1)
        set_reg(0, 8'h04); set_reg(3, 8'h10); set_reg(1, 8'h0F);
        set_reg(2, 8'h00); set_reg(5, 8'h00);
        wr(16'h0402, 8'h77);
        check("R7 planar write with oe read", plane_we, 4'hF);
        rd(16'h0403);
        check("R7 oe read with planar write", rd_plane, 2'd1);
        // write odd/even, read planar
        set_reg(0, 8'h00); set_reg(3, 8'hEF);
        wr(16'h0402, 8'h77);
        check("R7 oe write with planar read", plane_we, 4'b0101);
        rd(16'h0403);
        check("R7 planar read with oe write", rd_plane, 2'd0);
        check("R7 planar read addr", plane_addr, 16'h0403);
        idle();
    endtask

    task automatic t_misc();
        set_reg(4, 8'hFF);
        wr(16'h0403, 8'h12);
        check("R9 misc write no effect on we", plane_we, 4'b1010);
        check("R9 misc write no effect on addr", plane_addr, 16'h0402);
        rd(16'h0403);
        check("R9 misc write no effect on rd", rd_plane, 2'd0);
        idle();
    endtask

    task automatic t_reg_timing();
        set_reg(1, 8'h00);
        @(negedge clk);
        reg_we = 1; reg_sel = 1; host_wdata = 8'h0F;
        host_wr = 1; host_off = 16'h0010;
        #1;
        check("R10 same cycle uses old mask", plane_we, 4'h0);
        check("R10 shared data on plane_wdata", plane_wdata, 8'h0F);
        @(negedge clk);
        reg_we = 0; host_wdata = 8'hA5;
        #1;
        check("R10 new mask next cycle", plane_we, 4'b0101);
        idle();
    endtask

    task automatic t_idle();
        @(negedge clk);
        host_wr = 0; host_rd = 0; host_off = 16'h0011; host_wdata = 8'hC3;
        #1;
        check("R11 no strobe no we", plane_we, 4'h0);
        check("R11 wdata passthrough", plane_wdata, 8'hC3);
        check("R11 plane_rd idle", plane_rd, 1'b0);
        @(negedge clk);
        host_wr = 1; host_rd = 1;
        #1;
        check("R11 write wins plane_rd", plane_rd, 1'b0);
        host_wr = 0;
        #1;
        check("R11 read strobe", plane_rd, 1'b1);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_oe_write();
        t_page();
        t_seq_write();
        t_oe_read();
        t_indep();
        t_misc();
        t_reg_timing();
        t_idle();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule